// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller with Grouped Timer Sources

This block gathers interrupt events from one external pin, two periodic time-base ticks, a non-volatile memory write-done, an analog converter done, and a parameterised set of timer match events. Every event source has a sticky request flag. Each flag has an enable bit, and one global enable gates all of them. The timer match events are not handed to the processor one by one. They are gathered into grouped requests. Each group owns one vector and one group flag. Behind that group flag sit the individual match flags, which software inspects and clears.

At each instruction boundary the controller compares the flags that are pending. It raises a request to the processor core together with the vector address of the winner. The winner is the source with the lowest vector address. When the core acknowledges, two things happen on the same clock edge: the winning flag is cleared and the global enable drops, so a second interrupt cannot nest. A return-from-interrupt indication sets the global enable again. The external pin can be set to request on rising edges, falling edges, both edges or no edge. A wake indication is raised whenever any flag is pending together with its enable, whether or not the global enable is set.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source event sets that source's flag on the next clock edge, whether or not the source is enabled. The flag then stays set until it is cleared. Main flag index order: 0 pin, 1 tick 0, 2 tick 1, 3 memory done, 4 converter done, 5 and up timer groups.
- R2: The pin edge select works as follows. 00 sets no flag. 01 sets the flag on a rising edge. 10 sets it on a falling edge. 11 sets it on either edge. An edge is judged against the pin value registered on the previous clock.
- R3: `irq_req` is high only in a cycle where three things hold: `instr_boundary` is high, the global enable is set, and at least one flag is set with its enable bit set.
- R4: `irq_vector` is 0x04 + 4 × index, where index is the main flag index of the pending source. When several sources are pending, the lowest index wins. With default parameters the vectors run from 0x04 to 0x1C.
- R5: `irq_ack` has an effect only while `irq_req` is high. It then clears the winning flag and no other flag. If a new event for that same source arrives in the acknowledge cycle, the flag stays set. An acknowledge while `irq_req` is low changes nothing.
- R6: The global enable resets to 0. It is set by `gie_set` or `reti` and cleared by `gie_clr` or by a taken acknowledge. A clear wins over a set in the same cycle. After an acknowledge the enable stays 0 until it is set again.
- R7: Timer match flags are laid out as `sub_flags[g*S + k]`, with S matches per group; by default k=0 is the A match and k=1 is the P match. Each flag is set by its `tm_match` bit and is cleared only by the matching `sub_clr` bit. An acknowledge of the group vector does not clear them.
- R8: A group flag is set on an event of one of its match inputs whose `sub_en` bit is 1. An event on a disabled match input sets only that input's match flag. The group flag is cleared when its vector is acknowledged or through `flag_clr`.
- R9: `wake` is high whenever any flag is set together with its enable bit. It does not depend on the global enable or on `instr_boundary`.
- R10: A `flag_clr` bit clears its main flag on the next edge. If a set event arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, already synchronised |
| ext_edge_sel | input | 2 | Pin edge mode (R2) |
| tb_tick | input | 2 | Time-base tick pulses |
| nvm_done | input | 1 | Memory write-complete pulse |
| adc_done | input | 1 | Converter-complete pulse |
| tm_match | input | NUM_MF*SUBS_PER_MF | Timer match pulses |
| src_en | input | NSRC | Per-source enable bits |
| sub_en | input | NUM_MF*SUBS_PER_MF | Per-match enable bits into the group flags |
| flag_clr | input | NSRC | Software clear of main flags |
| sub_clr | input | NUM_MF*SUBS_PER_MF | Software clear of match flags |
| gie_set | input | 1 | Software set of the global enable |
| gie_clr | input | 1 | Software clear of the global enable |
| instr_boundary | input | 1 | High when the core can accept an interrupt |
| irq_ack | input | 1 | Core acknowledges the request |
| reti | input | 1 | Core is executing return-from-interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | VEC_W | Vector address of the winning source |
| flags | output | NSRC | Main request flags |
| sub_flags | output | NUM_MF*SUBS_PER_MF | Timer match flags |
| gie | output | 1 | Global enable |
| wake | output | 1 | Wake request for low-power modes |

## Verification
The bound checker verifies several properties on every cycle:
- a request only appears at a boundary while the global enable is set;
- the vector stays inside the table;
- a taken acknowledge drops the enable;
- an uncontested return sets it again;
- a match flag never clears without its clear bit;
- a request always comes with wake.

Other behaviours are visible only through the bench's scenarios:
- which source wins when several are pending, and the exact vector values;
- each edge mode;
- the group flag following only the enabled match inputs;
- the set-wins rule when an event and a clear share a cycle;
- an acknowledge with no request being ignored.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Fixed sources sit below the timer groups; the index sets priority and vector.
  localparam int unsigned FIXED_SRC = 5;
  localparam int unsigned IDX_PIN   = 0;
  localparam int unsigned IDX_TB0   = 1;
  localparam int unsigned IDX_TB1   = 2;
  localparam int unsigned IDX_NVM   = 3;
  localparam int unsigned IDX_ADC   = 4;

endpackage

// File: rtl/irqv_edge_det.sv
module irqv_edge_det
  import irqv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);

  logic       pin_q;
  logic       rise;
  logic       fall;
  edge_mode_e mode_e;

  always_comb begin
    mode_e = edge_mode_e'(mode);
    rise   = pin & ~pin_q;
    fall   = ~pin & pin_q;
    case (mode_e)
      EDGE_OFF:  hit = 1'b0;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin;
    end
  end

endmodule

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  // A set in the same cycle as a clear keeps the flag: no event is lost.
  always_comb begin
    q_nxt = (q_r & ~clr) | set;
    upd   = |(q_nxt ^ q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/irqv_mf_group.sv
module irqv_mf_group #(
  parameter int unsigned SUBS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUBS-1:0] sub_evt,
  input  logic [SUBS-1:0] sub_en,
  input  logic [SUBS-1:0] sub_clr,
  input  logic            mf_clr,
  output logic [SUBS-1:0] sub_q,
  output logic            mf_q
);

  logic mf_set;

  assign mf_set = |(sub_evt & sub_en);

  irqv_flag_bank #(.W(SUBS)) u_sub (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sub_evt),
    .clr   (sub_clr),
    .q     (sub_q)
  );

  irqv_flag_bank #(.W(1)) u_grp (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (mf_set),
    .clr   (mf_clr),
    .q     (mf_q)
  );

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned N     = 7,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned BASE  = 4,
  parameter int unsigned STEP  = 4
) (
  input  logic [N-1:0]     pending,
  output logic             any,
  output logic [VEC_W-1:0] vec,
  output logic [N-1:0]     grant
);

  // Scan from the top so the lowest index is written last and wins.
  always_comb begin
    any   = 1'b0;
    vec   = '0;
    grant = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any      = 1'b1;
        grant    = '0;
        grant[i] = 1'b1;
        vec      = VEC_W'(int'(BASE) + int'(STEP) * i);
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_MF      = 2,
  parameter int unsigned SUBS_PER_MF = 2,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned VEC_BASE    = 4,
  parameter int unsigned VEC_STEP    = 4,
  localparam int unsigned NSRC       = FIXED_SRC + NUM_MF,
  localparam int unsigned NSUB       = NUM_MF * SUBS_PER_MF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic [1:0]       ext_edge_sel,
  input  logic [1:0]       tb_tick,
  input  logic             nvm_done,
  input  logic             adc_done,
  input  logic [NSUB-1:0]  tm_match,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSUB-1:0]  sub_en,
  input  logic [NSRC-1:0]  flag_clr,
  input  logic [NSUB-1:0]  sub_clr,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             instr_boundary,
  input  logic             irq_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output logic [NSRC-1:0]  flags,
  output logic [NSUB-1:0]  sub_flags,
  output logic             gie,
  output logic             wake
);

  logic                 pin_hit;
  logic [FIXED_SRC-1:0] fixed_evt;
  logic [FIXED_SRC-1:0] fixed_q;
  logic [NSRC-1:0]      flag_all;
  logic [NSRC-1:0]      pending;
  logic [NSRC-1:0]      grant;
  logic [NSRC-1:0]      clr_main;
  logic                 any_pend;
  logic                 take;
  logic                 gie_q;
  logic                 gie_nxt;
  logic                 gie_upd;

  irqv_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .mode  (ext_edge_sel),
    .hit   (pin_hit)
  );

  always_comb begin
    fixed_evt          = '0;
    fixed_evt[IDX_PIN] = pin_hit;
    fixed_evt[IDX_TB0] = tb_tick[0];
    fixed_evt[IDX_TB1] = tb_tick[1];
    fixed_evt[IDX_NVM] = nvm_done;
    fixed_evt[IDX_ADC] = adc_done;
  end

  // A taken acknowledge clears only the granted flag.
  assign take     = irq_ack & irq_req;
  assign clr_main = flag_clr | (take ? grant : '0);

  irqv_flag_bank #(.W(FIXED_SRC)) u_fixed (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fixed_evt),
    .clr   (clr_main[FIXED_SRC-1:0]),
    .q     (fixed_q)
  );

  assign flag_all[FIXED_SRC-1:0] = fixed_q;

  genvar g;
  generate
    for (g = 0; g < NUM_MF; g++) begin : g_mf
      irqv_mf_group #(.SUBS(SUBS_PER_MF)) u_mf (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_evt (tm_match[g*SUBS_PER_MF +: SUBS_PER_MF]),
        .sub_en  (sub_en[g*SUBS_PER_MF +: SUBS_PER_MF]),
        .sub_clr (sub_clr[g*SUBS_PER_MF +: SUBS_PER_MF]),
        .mf_clr  (clr_main[FIXED_SRC+g]),
        .sub_q   (sub_flags[g*SUBS_PER_MF +: SUBS_PER_MF]),
        .mf_q    (flag_all[FIXED_SRC+g])
      );
    end
  endgenerate

  assign pending = flag_all & src_en & {NSRC{gie_q}};

  irqv_prio #(
    .N     (NSRC),
    .VEC_W (VEC_W),
    .BASE  (VEC_BASE),
    .STEP  (VEC_STEP)
  ) u_prio (
    .pending (pending),
    .any     (any_pend),
    .vec     (irq_vector),
    .grant   (grant)
  );

  assign irq_req = instr_boundary & any_pend;

  // Clear has the last word so entry always blocks nesting.
  always_comb begin
    gie_nxt = gie_q;
    if (gie_set | reti) begin
      gie_nxt = 1'b1;
    end
    if (gie_clr | take) begin
      gie_nxt = 1'b0;
    end
    gie_upd = gie_nxt ^ gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_upd) begin
      gie_q <= gie_nxt;
    end
  end

  assign flags = flag_all;
  assign gie   = gie_q;
  assign wake  = |(flag_all & src_en);

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_MF      = 2,
  parameter int unsigned SUBS_PER_MF = 2,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned VEC_BASE    = 4,
  parameter int unsigned VEC_STEP    = 4,
  localparam int unsigned NSRC       = FIXED_SRC + NUM_MF,
  localparam int unsigned NSUB       = NUM_MF * SUBS_PER_MF,
  localparam int unsigned VEC_LAST   = VEC_BASE + VEC_STEP * (NSRC - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             instr_boundary,
  input logic             gie,
  input logic             gie_clr,
  input logic             reti,
  input logic             wake,
  input logic [VEC_W-1:0] irq_vector,
  input logic [NSUB-1:0]  sub_flags,
  input logic [NSUB-1:0]  sub_clr
);

  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (instr_boundary && gie));

  p_vec_in_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector >= VEC_W'(VEC_BASE) && irq_vector <= VEC_W'(VEC_LAST)));

  p_entry_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !gie);

  p_reti_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !gie_clr && !(irq_req && irq_ack)) |=> gie);

  p_sub_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~sub_flags & $past(sub_flags & ~sub_clr)) == '0));

  p_req_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_MF      (NUM_MF),
  .SUBS_PER_MF (SUBS_PER_MF),
  .VEC_W       (VEC_W),
  .VEC_BASE    (VEC_BASE),
  .VEC_STEP    (VEC_STEP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_req        (irq_req),
  .irq_ack        (irq_ack),
  .instr_boundary (instr_boundary),
  .gie            (gie),
  .gie_clr        (gie_clr),
  .reti           (reti),
  .wake           (wake),
  .irq_vector     (irq_vector),
  .sub_flags      (sub_flags),
  .sub_clr        (sub_clr)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

  localparam int NSRC = 7;
  localparam int NSUB = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ext_pin;
  logic [1:0]      ext_edge_sel;
  logic [1:0]      tb_tick;
  logic            nvm_done;
  logic            adc_done;
  logic [NSUB-1:0] tm_match;
  logic [NSRC-1:0] src_en;
  logic [NSUB-1:0] sub_en;
  logic [NSRC-1:0] flag_clr;
  logic [NSUB-1:0] sub_clr;
  logic            gie_set;
  logic            gie_clr;
  logic            instr_boundary;
  logic            irq_ack;
  logic            reti;
  logic            irq_req;
  logic [7:0]      irq_vector;
  logic [NSRC-1:0] flags;
  logic [NSUB-1:0] sub_flags;
  logic            gie;
  logic            wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_sel(ext_edge_sel),
    .tb_tick(tb_tick), .nvm_done(nvm_done), .adc_done(adc_done), .tm_match(tm_match),
    .src_en(src_en), .sub_en(sub_en), .flag_clr(flag_clr), .sub_clr(sub_clr),
    .gie_set(gie_set), .gie_clr(gie_clr), .instr_boundary(instr_boundary),
    .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vector(irq_vector),
    .flags(flags), .sub_flags(sub_flags), .gie(gie), .wake(wake)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // Scoreboard driver: push the expected vector, then acknowledge at a boundary.
  task automatic take_irq(logic [7:0] expv);
    cyc();
    instr_boundary = 1'b1;
    irq_ack        = 1'b1;
    exp_q.push_back(expv);
    cyc();
    instr_boundary = 1'b0;
    irq_ack        = 1'b0;
  endtask

  task automatic do_reti();
    cyc();
    reti = 1'b1;
    cyc();
    reti = 1'b0;
  endtask

  task automatic drive_pin(logic v);
    cyc();
    ext_pin = v;
    cyc();
  endtask

  task automatic clr_main(logic [NSRC-1:0] m);
    cyc();
    flag_clr = m;
    cyc();
    flag_clr = '0;
  endtask

  // Monitor: every taken acknowledge pops one expected vector.
  always @(negedge clk) begin : mon
    logic [7:0] e;
    if (rst_n === 1'b1 && irq_req === 1'b1 && irq_ack === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 vector actual %h expected none", irq_vector);
      end else begin
        e = exp_q.pop_front();
        if (irq_vector !== e) begin
          fails++;
          $display("FAIL R4 vector actual %h expected %h", irq_vector, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; ext_pin = 1'b0; ext_edge_sel = 2'b00; tb_tick = '0;
    nvm_done = 1'b0; adc_done = 1'b0; tm_match = '0; src_en = '0; sub_en = '0;
    flag_clr = '0; sub_clr = '0; gie_set = 1'b0; gie_clr = 1'b0;
    instr_boundary = 1'b0; irq_ack = 1'b0; reti = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    settle();
    check("R1 reset flags", 32'(flags), 0);
    check("R6 reset gie", 32'(gie), 0);
    check("R3 reset req", 32'(irq_req), 0);

    // R1: flag set while disabled; R9: no wake without enable
    cyc(); tb_tick = 2'b01; cyc(); tb_tick = 2'b00; settle();
    check("R1 tick0 flag", 32'(flags), 32'h02);
    check("R9 wake needs enable", 32'(wake), 0);

    // R3: gating by enable, boundary, global enable
    cyc(); gie_set = 1'b1; cyc(); gie_set = 1'b0; instr_boundary = 1'b1; settle();
    check("R6 gie_set", 32'(gie), 1);
    check("R3 no req when disabled", 32'(irq_req), 0);
    cyc(); src_en = 7'b0000010; instr_boundary = 1'b0; settle();
    check("R3 no req off boundary", 32'(irq_req), 0);
    check("R9 wake", 32'(wake), 1);
    cyc(); instr_boundary = 1'b1; settle();
    check("R3 req at boundary", 32'(irq_req), 1);
    check("R4 tick0 vector", 32'(irq_vector), 32'h08);
    cyc(); instr_boundary = 1'b0;
    cyc(); gie_clr = 1'b1; cyc(); gie_clr = 1'b0; instr_boundary = 1'b1; settle();
    check("R3 no req without gie", 32'(irq_req), 0);
    check("R9 wake ignores gie", 32'(wake), 1);
    cyc(); instr_boundary = 1'b0; gie_set = 1'b1; cyc(); gie_set = 1'b0;

    // R4/R5/R6: priority ordering through successive acknowledges
    cyc(); tb_tick = 2'b10; nvm_done = 1'b1; adc_done = 1'b1;
    cyc(); tb_tick = 2'b00; nvm_done = 1'b0; adc_done = 1'b0; src_en = 7'b0011110;
    settle();
    check("R1 several flags", 32'(flags), 32'h1E);
    take_irq(8'h08); settle();
    check("R5 only winner cleared", 32'(flags), 32'h1C);
    check("R6 gie dropped on entry", 32'(gie), 0);
    cyc(); cyc(); settle();
    check("R6 gie stays 0 without reti", 32'(gie), 0);
    do_reti(); settle();
    check("R6 reti restores gie", 32'(gie), 1);
    take_irq(8'h0C); do_reti();
    take_irq(8'h10); do_reti();
    take_irq(8'h14); do_reti(); settle();
    check("R5 all taken", 32'(flags), 0);

    // R2: pin edge modes
    src_en = 7'b0000000;
    drive_pin(1'b1); settle(); check("R2 mode 00 rise", 32'(flags[0]), 0);
    drive_pin(1'b0); settle(); check("R2 mode 00 fall", 32'(flags[0]), 0);
    ext_edge_sel = 2'b01;
    drive_pin(1'b1); settle(); check("R2 mode 01 rise", 32'(flags[0]), 1);
    clr_main(7'b0000001);
    drive_pin(1'b0); settle(); check("R2 mode 01 fall", 32'(flags[0]), 0);
    ext_edge_sel = 2'b10;
    drive_pin(1'b1); settle(); check("R2 mode 10 rise", 32'(flags[0]), 0);
    drive_pin(1'b0); settle(); check("R2 mode 10 fall", 32'(flags[0]), 1);
    clr_main(7'b0000001);
    ext_edge_sel = 2'b11;
    drive_pin(1'b1); settle(); check("R2 mode 11 rise", 32'(flags[0]), 1);
    clr_main(7'b0000001);
    drive_pin(1'b0); settle(); check("R2 mode 11 fall", 32'(flags[0]), 1);
    clr_main(7'b0000001); settle();
    check("R10 clear pin flag", 32'(flags[0]), 0);

    // R7/R8: grouped timer requests
    src_en = 7'b1100000; sub_en = 4'b0001;
    cyc(); tm_match = 4'b0010; cyc(); tm_match = '0; settle();
    check("R7 disabled match sets sub flag", 32'(sub_flags), 32'h2);
    check("R8 disabled match no group flag", 32'(flags[5]), 0);
    cyc(); tm_match = 4'b0001; cyc(); tm_match = '0; settle();
    check("R8 enabled match sets group flag", 32'(flags[5]), 1);
    take_irq(8'h18); settle();
    check("R8 group flag cleared on take", 32'(flags[5]), 0);
    check("R7 sub flags survive take", 32'(sub_flags), 32'h3);
    do_reti();
    cyc(); sub_clr = 4'b0011; cyc(); sub_clr = '0; settle();
    check("R7 sub clear", 32'(sub_flags), 0);
    sub_en = 4'b1000;
    cyc(); tm_match = 4'b1100; cyc(); tm_match = '0; settle();
    check("R8 group1 flag", 32'(flags[6]), 1);
    take_irq(8'h1C); do_reti(); settle();
    check("R8 group1 cleared", 32'(flags), 0);
    cyc(); sub_clr = 4'b1100; cyc(); sub_clr = '0;

    // R5: event in acknowledge cycle keeps the flag; ack without request ignored
    src_en = 7'b0000010;
    cyc(); tb_tick = 2'b01; cyc(); tb_tick = 2'b00;
    cyc(); instr_boundary = 1'b1; irq_ack = 1'b1; tb_tick = 2'b01; exp_q.push_back(8'h08);
    cyc(); instr_boundary = 1'b0; irq_ack = 1'b0; tb_tick = 2'b00; settle();
    check("R5 same-cycle event keeps flag", 32'(flags[1]), 1);
    do_reti();
    cyc(); irq_ack = 1'b1; cyc(); irq_ack = 1'b0; settle();
    check("R5 ack without req flag", 32'(flags[1]), 1);
    check("R5 ack without req gie", 32'(gie), 1);

    // R10: clear versus set in one cycle
    cyc(); flag_clr = 7'b0000010; tb_tick = 2'b01;
    cyc(); flag_clr = '0; tb_tick = 2'b00; settle();
    check("R10 set wins over clear", 32'(flags[1]), 1);
    clr_main(7'b0000010); settle();
    check("R10 clear alone", 32'(flags[1]), 0);

    // R6: clear wins over reti
    cyc(); reti = 1'b1; gie_clr = 1'b1; cyc(); reti = 1'b0; gie_clr = 1'b0; settle();
    check("R6 clear wins", 32'(gie), 0);

    check("R4 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule